// File: doc/BRIEF.md
# I2C Register Slave with Saturating Pointer

This block is a 7-bit-address I2C target that gives a host bus master access to a bank of 8-bit control registers numbered 00h through 16h. It oversamples SCL and SDA with the system clock. It recognises START, repeated START and STOP conditions, matches its own address, and acknowledges the bytes it receives. SDA is open-drain: the block only ever pulls the line low, through a drive-enable output.

The first byte of a write transfer sets an internal register pointer. Every later byte in that transfer is written to the register the pointer selects, and the pointer then advances by one. The pointer stops at the last register, 16h: once it is there, any further bytes keep going to 16h.

A read sends the contents of the register at the pointer. The pointer is either the one left by the previous access, or one set just before by a write phase and a repeated START. The register file lives outside the block. The block drives a one-cycle write strobe with an address and data. It presents the pointer as a read address and takes the selected register's contents back combinationally.

Top module: `i2c_regslave`

## Requirements
- R1: The block answers the device address 1100011b. The eighth bit of the address byte selects the direction: 0 means write and 1 means read. A matching address byte is acknowledged.
- R2: When the address byte does not match, SDA is never driven and no register is written until the next START.
- R3: After each byte it receives (a matching address, a pointer or data), the block pulls SDA low for exactly the ninth SCL clock.
- R4: In a write, the first byte after the address loads the pointer, and any value above 16h loads 16h. Each later byte gives one single-cycle write strobe carrying the pointer and the byte.
- R5: The pointer advances by one after every completed data byte, whether written or read, and stays at 16h once it has reached 16h.
- R6: A read with no preceding pointer byte starts at the pointer left by the previous access.
- R7: After a repeated START, a read (R/W=1) begins at the pointer just loaded. A write (R/W=0) takes a fresh pointer byte and then writes data.
- R8: Read data goes out MSB first, and SDA changes only while SCL is low. A master ACK continues with the next register. A master NACK releases SDA until the next START.
- R9: A STOP at any point, including in the middle of a byte, returns the block to idle with SDA released. A STOP followed directly by a START, or a START followed directly by a STOP, is accepted.
- R10: After reset, SDA is released, the pointer is 00h and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When 1, SDA is pulled low |
| reg_wr_en | output | 1 | Single-cycle register write strobe |
| reg_wr_addr | output | PW | Register index for the write |
| reg_wr_data | output | 8 | Byte to write |
| rd_addr | output | PW | Current pointer, used as the register read index |
| rd_data | input | 8 | Contents of register rd_addr |

## Verification
At the end of a received data byte, the write strobe and the pointer step fall on the same edge. At 16h, the pointer step also meets the saturation. This case is provoked with a burst of writes that starts at 14h and runs past 16h. It is judged by checking that 15h holds the second byte, that 16h holds only the last byte, and that the pointer reads back as 16h. On the read side, the pointer step coincides with fetching the next byte. A pointer-less read that follows a burst shows whether the fetched byte and the advanced pointer agree.

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter logic [6:0] DEV_ADDR = 7'h63,
  parameter int LAST_REG = 22,
  localparam int PW = $clog2(LAST_REG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          reg_wr_en,
  output logic [PW-1:0] reg_wr_addr,
  output logic [7:0]    reg_wr_data,
  output logic [PW-1:0] rd_addr,
  input  logic [7:0]    rd_data
);

  localparam logic [PW-1:0] LAST_P = PW'(LAST_REG);

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} kind_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  st_t        st;
  kind_t      kind;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic       rd_mode, mack;
  logic [PW-1:0] ptr;

  function automatic logic [PW-1:0] clamp(input logic [7:0] v);
    return (int'(v) > LAST_REG) ? LAST_P : v[PW-1:0];
  endfunction

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST_P) ? p : p + PW'(1);
  endfunction

  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign rd_addr   = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      kind        <= K_ADDR;
      sh          <= '0;
      cnt         <= '0;
      rd_mode     <= 1'b0;
      mack        <= 1'b0;
      ptr         <= '0;
      sda_oe      <= 1'b0;
      reg_wr_en   <= 1'b0;
      reg_wr_addr <= '0;
      reg_wr_data <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      if (start_det) begin
        st     <= ST_RX;
        kind   <= K_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              case (kind)
                K_ADDR: begin
                  if (sh[7:1] == DEV_ADDR) begin
                    rd_mode <= sh[0];
                    sda_oe  <= 1'b1;
                    st      <= ST_RX_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                K_PTR: begin
                  ptr    <= clamp(sh);
                  sda_oe <= 1'b1;
                  st     <= ST_RX_ACK;
                end
                default: begin
                  reg_wr_en   <= 1'b1;
                  reg_wr_addr <= ptr;
                  reg_wr_data <= sh;
                  ptr         <= step(ptr);
                  sda_oe      <= 1'b1;
                  st          <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (kind == K_ADDR && rd_mode) begin
                st     <= ST_TX;
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
              end else begin
                st     <= ST_RX;
                sda_oe <= 1'b0;
                kind   <= (kind == K_ADDR) ? K_PTR : K_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                ptr    <= step(ptr);
                st     <= ST_TX_ACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                st     <= ST_TX;
                cnt    <= '0;
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_IDLE |-> (!sda_oe && !reg_wr_en));

  a_r3_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RX_ACK && !scl_fall && !start_det && !stop_det) |=> sda_oe);

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  a_r4_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> reg_wr_addr <= LAST_P);

  a_r5_ptr_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == LAST_P && !(st == ST_RX && kind == K_PTR)) |=> rd_addr == LAST_P);

  a_r8_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && st == ST_IDLE));

endmodule

// File: tb/i2c_regslave_tb_top.sv
module i2c_regslave_tb_top;
  localparam int PW = 5;
  localparam int Q = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_wr_en;
  logic [PW-1:0] reg_wr_addr, rd_addr;
  logic [7:0] reg_wr_data, rd_data;
  wire sda_line = sda_m & ~sda_oe;

  i2c_regslave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  logic [7:0] regs [0:22];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 23; i++) regs[i] <= 8'h40 + 8'(i);
    end else if (reg_wr_en) begin
      regs[reg_wr_addr] <= reg_wr_data;
    end
  end
  assign rd_data = (rd_addr <= 5'd22) ? regs[rd_addr] : 8'h00;

  int checks = 0, errors = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sat(input int a);
    return (a > 22) ? 22 : a;
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    acked = (sda_line == 1'b0);
    scl_m = 1'b0; wq();
  endtask

  task automatic get_byte(input bit ack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
      b = {b[6:0], sda_line};
      scl_m = 1'b0; wq();
    end
    sda_m = ack ? 1'b0 : 1'b1; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  localparam logic [15:0] VEC [6] = '{16'h00A5, 16'h053C, 16'h1577, 16'h16E1, 16'h2A19, 16'h0B00};

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 sda released", sda_oe, 0);
    chk("R10 pointer", rd_addr, 0);
    chk("R10 strobe", reg_wr_en, 0);

    for (int i = 0; i < 6; i++) begin
      int p, e;
      p = VEC[i][15:8];
      e = sat(p);
      i2c_start();
      put_byte(8'hC6, a); chk("R1 address ack", a, 1);
      put_byte(VEC[i][15:8], a); chk("R3 pointer ack", a, 1);
      put_byte(VEC[i][7:0], a); chk("R3 data ack", a, 1);
      i2c_stop();
      chk("R4 written value", regs[e], VEC[i][7:0]);
      chk("R5 pointer after write", rd_addr, sat(e + 1));
      i2c_start();
      put_byte(8'hC6, a);
      put_byte(VEC[i][15:8], a);
      i2c_start();
      put_byte(8'hC7, a); chk("R7 read address ack", a, 1);
      get_byte(1'b0, d);
      i2c_stop();
      chk("R7 combined read", d, VEC[i][7:0]);
      chk("R5 pointer after read", rd_addr, sat(e + 1));
    end

    // R2: foreign address
    i2c_start();
    put_byte(8'hC4, a); chk("R2 no ack on address", a, 0);
    put_byte(8'h03, a); chk("R2 no ack on later byte", a, 0);
    put_byte(8'hFF, a); chk("R2 sda idle", sda_oe, 0);
    i2c_stop();
    chk("R2 register untouched", regs[3], 8'h43);
    chk("R2 pointer untouched", rd_addr, sat(8'h0B + 1));

    // R5: burst across the top register
    i2c_start();
    put_byte(8'hC6, a); put_byte(8'h14, a);
    put_byte(8'h11, a); put_byte(8'h22, a); put_byte(8'h33, a); put_byte(8'h44, a);
    i2c_stop();
    chk("R5 burst 14h", regs[20], 8'h11);
    chk("R5 burst 15h", regs[21], 8'h22);
    chk("R5 burst 16h holds last", regs[22], 8'h44);
    chk("R5 pointer saturated", rd_addr, 22);

    // R6 / R8: pointer-only write, then plain reads
    i2c_start(); put_byte(8'hC6, a); put_byte(8'h02, a); i2c_stop();
    i2c_start(); put_byte(8'hC7, a);
    get_byte(1'b1, d); chk("R6 first plain read", d, 8'h42);
    get_byte(1'b1, d); chk("R8 ack continues", d, 8'h43);
    get_byte(1'b0, d); chk("R8 third byte", d, 8'h44);
    wq(); wq();
    chk("R8 released after nack", sda_oe, 0);
    i2c_stop();
    i2c_start(); put_byte(8'hC7, a);
    get_byte(1'b0, d); chk("R6 read continues", d, 8'h3C);
    i2c_stop();
    chk("R5 pointer after plain read", rd_addr, 6);

    // R7: repeated start with write direction
    i2c_start(); put_byte(8'hC6, a); put_byte(8'h08, a);
    i2c_start(); put_byte(8'hC6, a); put_byte(8'h09, a); put_byte(8'h5A, a);
    i2c_stop();
    chk("R7 rewrite target", regs[9], 8'h5A);
    chk("R7 first pointer not written", regs[8], 8'h48);
    i2c_start(); put_byte(8'hC6, a); put_byte(8'h09, a);
    i2c_start(); put_byte(8'hC7, a);
    get_byte(1'b0, d); i2c_stop();
    chk("R8 msb first pattern", d, 8'h5A);

    // R9: stop mid-byte, back-to-back start/stop
    i2c_start();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    i2c_stop();
    chk("R9 released after mid-byte stop", sda_oe, 0);
    i2c_start(); i2c_stop();
    i2c_start(); put_byte(8'hC6, a); chk("R9 ack after quick start", a, 1);
    put_byte(8'h10, a); put_byte(8'h99, a);
    i2c_stop();
    chk("R9 write after back-to-back", regs[16], 8'h99);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule